// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous binary up-counter of parameterised width, four bits by default, so it counts modulo 16. It has an active-low parallel-load input and two count enables, called parallel and trickle. A terminal-count output lets several stages be chained into one wider counter that is still fully synchronous. Typical uses are programmable dividers and wide event counters.

All stages in a chain share the clock and the load input. The first stage gets the global enable on both of its enables. Each later stage takes the terminal count of the stage before it on its trickle enable, and the global enable on its parallel enable.

A compile-time parameter chooses the reset mode. In one mode the reset acts at once and asynchronously. In the other it takes effect on the rising edge. The input priority is fixed: reset, then load, then count, then hold.

Top module: `cascade_bin_counter`

## Requirements
- R1: When counting from the all-ones state (15 at the default width), the state wraps to 0 on the next rising edge.
- R2: Apart from an asynchronous reset, the state changes only on a rising clock edge. Between edges it stays constant while the inputs change.
- R3: With reset inactive and load_ni low, the state takes the value of data_i on the next rising edge, whatever the two count enables are.
- R4: With reset inactive, load_ni high and both count enables high, the state increases by one on each rising edge.
- R5: With reset inactive, load_ni high and either count enable low, the state holds its value.
- R6: tc_o is high exactly when the state is all ones and cnt_trk_i is high. It does not depend on cnt_par_i or on load_ni.
- R7: With SYNC_RESET=0, rst_ni low forces the state and tc_o to 0 at once. This overrides the clock, the load and the enables for as long as rst_ni stays low.
- R8: With SYNC_RESET=1, rst_ni low clears the state on the next rising edge and overrides both loading and counting. Until that edge the state keeps its value.
- R9: Two stages with the first stage's tc_o wired to the second stage's cnt_trk_i form one 8-bit counter. It loads, counts with a carry between the stages, wraps from 255 to 0, and raises the upper stage's tc_o only at 255 while the chain is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset, asynchronous or synchronous according to SYNC_RESET |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Value loaded while load_ni is low |
| cnt_par_i | input | 1 | Parallel count enable |
| cnt_trk_i | input | 1 | Trickle count enable; also gates tc_o |
| count_o | output | WIDTH | Counter state |
| tc_o | output | 1 | Terminal count: state all ones and cnt_trk_i high |

## Verification
A single stage is tried in each reset mode with the same stimulus:
- Runs of counting that cross the wrap point separate correct modulo behaviour from saturation or off-by-one errors.
- Loads made with both enables low, and with both high, separate a correct priority from one where counting wins over loading.
- Holds with only one enable low show that each enable is needed on its own.
- Holding the state at all ones while toggling the trickle enable, the parallel enable and the load shows that tc_o follows only the state and the trickle enable.
- A reset dropped between clock edges while a load is pending separates the two reset modes: one output clears at once, the other waits for the edge.

A two-stage chain is then loaded just below the nibble boundary and just below 255 and run across both, so that the carry between the stages is checked against an 8-bit reference count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    cnt_par_i,
  input  logic    cnt_trk_i,
  output cnt_op_e op_o
);
  // reset is applied in the state register, above all of these
  always_comb begin
    if (!load_ni)                    op_o = OP_LOAD;
    else if (cnt_par_i && cnt_trk_i) op_o = OP_COUNT;
    else                             op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] incr;

  // ripple incrementer: bit k toggles when all lower bits are set
  assign carry[0] = 1'b1;
  for (genvar k = 0; k < WIDTH; k++) begin : g_inc
    assign incr[k]    = cur_i[k] ^ carry[k];
    assign carry[k+1] = cur_i[k] & carry[k];
  end

  always_comb begin
    case (op_i)
      OP_LOAD:  nxt_o = data_i;
      OP_COUNT: nxt_o = incr;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH      = 4,
  parameter bit SYNC_RESET = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (SYNC_RESET) begin : g_sync
    always_ff @(posedge clk_i) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_async
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             cnt_trk_i,
  output logic             tc_o
);
  assign tc_o = (&cnt_i) & cnt_trk_i;
endmodule

// File: rtl/cascade_bin_counter.sv
module cascade_bin_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit SYNC_RESET = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cnt_par_i,
  input  logic             cnt_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;

  cnt_ctrl i_ctrl (
    .load_ni   (load_ni),
    .cnt_par_i (cnt_par_i),
    .cnt_trk_i (cnt_trk_i),
    .op_o      (op)
  );

  cnt_next #(.WIDTH(WIDTH)) i_next (
    .op_i   (op),
    .cur_i  (count_o),
    .data_i (data_i),
    .nxt_o  (nxt)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .SYNC_RESET(SYNC_RESET)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (count_o)
  );

  cnt_tc #(.WIDTH(WIDTH)) i_tc (
    .cnt_i     (count_o),
    .cnt_trk_i (cnt_trk_i),
    .tc_o      (tc_o)
  );
endmodule

// File: rtl/cnt_chk.sv
module cnt_chk #(
  parameter int WIDTH      = 4,
  parameter bit SYNC_RESET = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             cnt_par_i,
  input logic             cnt_trk_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R1
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && load_ni && cnt_par_i && cnt_trk_i && count_o == TOP) |=> count_o == '0);

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !load_ni) |=> count_o == $past(data_i));

  // R4
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && load_ni && cnt_par_i && cnt_trk_i) |=> count_o == $past(count_o) + WIDTH'(1));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && load_ni && !(cnt_par_i && cnt_trk_i)) |=> $stable(count_o));

  // R6
  tc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && load_ni && tc_o && cnt_par_i) |=> count_o == '0);

  if (SYNC_RESET) begin : g_sync_chk
    // R8
    sync_clr_chk: assert property (@(posedge clk_i)
      !rst_ni |=> count_o == '0);
  end else begin : g_async_chk
    // R7
    async_clr_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (count_o == '0 && !tc_o));
  end
endmodule

bind cascade_bin_counter cnt_chk #(.WIDTH(WIDTH), .SYNC_RESET(SYNC_RESET)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .cnt_par_i (cnt_par_i),
  .cnt_trk_i (cnt_trk_i),
  .count_o   (count_o),
  .tc_o      (tc_o)
);

// File: tb/test_cascade_bin_counter.sv
module test_cascade_bin_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, ld_n, p, t;
  logic [3:0] d;
  logic [3:0] qa, qs;
  logic       tca, tcs;

  logic       cas_ld_n, cas_ce;
  logic [7:0] cas_d;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  int n_chk = 0, n_fail = 0;
  int ma = 0, ms = 0, mc = 0;

  cascade_bin_counter #(.WIDTH(4), .SYNC_RESET(1'b0)) i_cascade_bin_counter (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(ld_n), .data_i(d),
    .cnt_par_i(p), .cnt_trk_i(t), .count_o(qa), .tc_o(tca));

  cascade_bin_counter #(.WIDTH(4), .SYNC_RESET(1'b1)) i_cascade_bin_counter_sync (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(ld_n), .data_i(d),
    .cnt_par_i(p), .cnt_trk_i(t), .count_o(qs), .tc_o(tcs));

  cascade_bin_counter #(.WIDTH(4)) i_cascade_bin_counter_lo (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(cas_ld_n), .data_i(cas_d[3:0]),
    .cnt_par_i(cas_ce), .cnt_trk_i(cas_ce), .count_o(lo_q), .tc_o(lo_tc));

  cascade_bin_counter #(.WIDTH(4)) i_cascade_bin_counter_hi (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(cas_ld_n), .data_i(cas_d[7:4]),
    .cnt_par_i(cas_ce), .cnt_trk_i(lo_tc), .count_o(hi_q), .tc_o(hi_tc));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(int cur, bit r, bit l, int dd, bit pp, bit tt);
    if (!r)           return 0;
    else if (!l)      return dd;
    else if (pp && tt) return (cur + 1) % 16;
    else              return cur;
  endfunction

  task automatic step(bit r, bit l, int dd, bit pp, bit tt, string tag);
    @(negedge clk);
    rst_n = r; ld_n = l; d = 4'(dd); p = pp; t = tt;
    #1;
    if (!r) begin
      ma = 0;
      chk(qa == 4'(ma), "R7 async clear before edge", int'(qa), ma);
      chk(qs == 4'(ms), "R8 sync holds before edge", int'(qs), ms);
    end else begin
      chk(qa == 4'(ma), "R2 async stable between edges", int'(qa), ma);
      chk(qs == 4'(ms), "R2 sync stable between edges", int'(qs), ms);
    end
    @(posedge clk);
    ma = nxt(ma, r, l, dd, pp, tt);
    ms = nxt(ms, r, l, dd, pp, tt);
    #2;
    chk(qa == 4'(ma), {tag, " async state"}, int'(qa), ma);
    chk(qs == 4'(ms), {tag, " sync state"}, int'(qs), ms);
    chk(tca == (ma == 15 && tt), "R6 async tc", int'(tca), int'(ma == 15 && tt));
    chk(tcs == (ms == 15 && tt), "R6 sync tc", int'(tcs), int'(ms == 15 && tt));
  endtask

  task automatic mid_reset();
    @(negedge clk);
    ld_n = 1'b0; d = 4'd9; p = 1'b1; t = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    chk(qa == 4'd0, "R7 immediate clear", int'(qa), 0);
    chk(tca == 1'b0, "R7 tc low in reset", int'(tca), 0);
    chk(qs == 4'(ms), "R8 no clear before edge", int'(qs), ms);
    @(posedge clk);
    ma = 0; ms = 0;
    #2;
    chk(qa == 4'd0, "R7 reset beats load", int'(qa), 0);
    chk(qs == 4'd0, "R8 reset beats load", int'(qs), 0);
  endtask

  task automatic cstep(bit l, int dd, bit ce);
    @(negedge clk);
    cas_ld_n = l; cas_d = 8'(dd); cas_ce = ce;
    @(posedge clk);
    if (!l)      mc = dd;
    else if (ce) mc = (mc + 1) % 256;
    #2;
    chk({hi_q, lo_q} == 8'(mc), "R9 cascade value", int'({hi_q, lo_q}), mc);
    chk(hi_tc == (mc == 255 && ce), "R9 cascade tc", int'(hi_tc), int'(mc == 255 && ce));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_600_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ld_n = 1'b1; d = 4'd0; p = 1'b0; t = 1'b0;
    cas_ld_n = 1'b1; cas_d = 8'd0; cas_ce = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk(qa == 4'd0, "R7 reset state", int'(qa), 0);
    chk(qs == 4'd0, "R8 reset state", int'(qs), 0);
    chk(tca == 1'b0, "R7 tc in reset", int'(tca), 0);
    chk({hi_q, lo_q} == 8'd0, "R9 reset state", int'({hi_q, lo_q}), 0);

    step(1, 0, 13, 0, 0, "R3 load with enables low");
    step(1, 1, 0, 1, 1, "R4 count");
    step(1, 1, 0, 1, 1, "R4 count to top");
    step(1, 1, 0, 1, 1, "R1 wrap");
    step(1, 0, 15, 0, 1, "R3 load top");
    step(1, 1, 0, 0, 1, "R5 hold par low");
    step(1, 1, 0, 1, 0, "R5 hold trk low");
    step(1, 1, 0, 0, 0, "R5 hold both low");
    step(1, 0, 3, 1, 1, "R3 load over count");
    step(1, 1, 0, 1, 1, "R4 count");
    step(1, 0, 15, 1, 1, "R3 load top with enables");
    step(1, 0, 15, 1, 1, "R6 tc during load");
    step(0, 0, 10, 1, 1, "R7 reset over load");
    step(1, 0, 7, 1, 1, "R3 load after reset");
    step(1, 1, 0, 1, 1, "R4 count");
    mid_reset();
    step(1, 1, 0, 1, 1, "R4 count after reset");
    for (int i = 0; i < 40; i++)
      step(1, (i % 7) != 3, (i * 5) % 16, (i % 3) != 0, (i % 5) != 1, "R4 mixed");

    cstep(0, 8'h0D, 0);
    for (int i = 0; i < 4; i++) cstep(1, 0, 1);
    cstep(1, 0, 0);
    cstep(0, 8'hFB, 1);
    for (int i = 0; i < 7; i++) cstep(1, 0, 1);
    cstep(0, 8'hFF, 0);
    cstep(1, 0, 1);
    finish_run();
  end
endmodule